// File: doc/BRIEF.md
# Sleep Mode Clock-Gating Controller

This block decides which clock domains of a small controller keep running while the processor sleeps. It handles five domains: the processor core, the general I/O peripherals, the asynchronous timer, the converter and the main oscillator. Software arms the block with a sleep-enable level and then issues a one-cycle sleep request together with a 3-bit mode code. The block latches that code and drops the enables of the domains the mode stops. It keeps them low until a permitted interrupt or a reset request arrives.

Wake interrupts pass a per-mode filter. In the three deepest modes, only interrupt lines flagged as able to run without the I/O clock can wake the block. When the oscillator itself was stopped, the restart runs through a wait phase. In that phase only the oscillator enable is high, and the wait lasts for a programmable number of reference ticks. After every wake, a one-cycle pulse reports the mode code that was left. A reset request overrides everything. It forces every enable high combinationally and returns the controller to the run state.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, all five enables are 1, `wake_pulse_o` is 0 and `wake_mode_o` is 000.
- R2: A sleep request is accepted only when `sleep_en_i` is 1 and `mode_i` is one of 000, 001, 010, 011 or 110. Any other request leaves all enables at 1.
- R3: One cycle after an accepted request, the enables {cpu,io,async,adc,osc} are set by the mode code: 000 gives 01111, 001 gives 00111, 010 gives 00000, 011 gives 00100, and 110 gives 00001.
- R4: A wake needs `irq_i & irq_en_i` to be non-zero. For codes 010, 011 and 110, the line must also have its `irq_async_i` bit set. A masked or filtered line does not change the enables.
- R5: A wake from code 010 or 011 first holds the enables at 00001. The block counts rising `ref_tick_i` samples, and one cycle after the count reaches `startup_ticks_i`, all enables return to 1. A value of 0 exits after a single wait cycle.
- R6: A wake from code 000, 001 or 110 sets all enables to 1 in the cycle after the wake interrupt is sampled.
- R7: While `rst_req_i` is 1, all enables are 1 in the same cycle. The next clock edge returns the block to run with no wake pulse, and this takes priority over a wake in the same cycle.
- R8: On the cycle when all enables return to 1 after a wake, `wake_pulse_o` is 1 for exactly one cycle, and `wake_mode_o` holds the code of the mode that was left.
- R9: A sleep request that arrives while the block is asleep or waiting is ignored. The latched mode and the enables do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_en_i | input | 1 | Arms acceptance of sleep requests |
| sleep_req_i | input | 1 | One-cycle sleep request strobe |
| mode_i | input | 3 | Requested mode code |
| irq_i | input | N_IRQ | Pending interrupt lines |
| irq_en_i | input | N_IRQ | Per-line interrupt enable |
| irq_async_i | input | N_IRQ | Line can wake without I/O clock |
| rst_req_i | input | 1 | Reset request, forces all clocks on |
| ref_tick_i | input | 1 | Oscillator start-up reference tick |
| startup_ticks_i | input | CNT_W | Ticks to wait after oscillator restart |
| clk_en_cpu_o | output | 1 | Core clock enable |
| clk_en_io_o | output | 1 | I/O peripheral clock enable |
| clk_en_async_o | output | 1 | Asynchronous timer clock enable |
| clk_en_adc_o | output | 1 | Converter clock enable |
| clk_en_osc_o | output | 1 | Main oscillator enable |
| wake_pulse_o | output | 1 | One-cycle wake report |
| wake_mode_o | output | 3 | Mode code that was exited |

## Verification
Two functions can land on the same clock edge: a reset request and a filtered wake interrupt. Either can happen in Power-down, and either can happen during the oscillator wait. The bench raises `rst_req_i` and an asynchronous-capable interrupt together while the block is asleep in code 010. The reference model gives the reset priority, so it expects all enables high at once, no wake pulse on the next cycle, and no wait phase. A second case asserts the reset request in the middle of the start-up wait. There, the model expects the count to be abandoned and no pulse to appear.

// File: rtl/sleep_ctrl_pkg.sv
package sleep_ctrl_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE  = 3'b000,
    MODE_ADCNR = 3'b001,
    MODE_PDOWN = 3'b010,
    MODE_PSAVE = 3'b011,
    MODE_STBY  = 3'b110
  } sleep_mode_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WAIT  = 2'd2
  } ctrl_state_e;

  typedef struct packed {
    logic cpu;
    logic io;
    logic async_tmr;
    logic adc;
    logic osc;
  } dom_en_t;

  localparam dom_en_t DOM_ALL_ON  = 5'b11111;
  localparam dom_en_t DOM_OSC_ONLY = 5'b00001;

endpackage

// File: rtl/sleep_mode_decode.sv
module sleep_mode_decode
  import sleep_ctrl_pkg::*;
(
  input  logic [2:0] mode_i,
  output logic       valid_o,
  output logic       async_only_o,
  output logic       slow_wake_o,
  output dom_en_t    keep_o
);

  always_comb begin
    valid_o      = 1'b1;
    async_only_o = 1'b0;
    slow_wake_o  = 1'b0;
    keep_o       = DOM_ALL_ON;
    case (mode_i)
      MODE_IDLE: begin
        keep_o = '{cpu: 1'b0, io: 1'b1, async_tmr: 1'b1, adc: 1'b1, osc: 1'b1};
      end
      MODE_ADCNR: begin
        keep_o = '{cpu: 1'b0, io: 1'b0, async_tmr: 1'b1, adc: 1'b1, osc: 1'b1};
      end
      MODE_PDOWN: begin
        keep_o       = '{cpu: 1'b0, io: 1'b0, async_tmr: 1'b0, adc: 1'b0, osc: 1'b0};
        async_only_o = 1'b1;
        slow_wake_o  = 1'b1;
      end
      MODE_PSAVE: begin
        keep_o       = '{cpu: 1'b0, io: 1'b0, async_tmr: 1'b1, adc: 1'b0, osc: 1'b0};
        async_only_o = 1'b1;
        slow_wake_o  = 1'b1;
      end
      MODE_STBY: begin
        keep_o       = '{cpu: 1'b0, io: 1'b0, async_tmr: 1'b0, adc: 1'b0, osc: 1'b1};
        async_only_o = 1'b1;
      end
      default: begin
        valid_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/sleep_wake_filter.sv
module sleep_wake_filter #(
  parameter int unsigned N_IRQ = 4
) (
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic [N_IRQ-1:0] irq_async_i,
  input  logic             async_only_i,
  output logic             wake_o
);

  logic [N_IRQ-1:0] line_ok;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_line
    // I/O-clocked sources are blind when the I/O clock is stopped
    assign line_ok[g] = irq_i[g] & irq_en_i[g] & (irq_async_i[g] | ~async_only_i);
  end

  assign wake_o = |line_ok;

endmodule

// File: rtl/sleep_osc_timer.sv
module sleep_osc_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clear_i)     cnt_q <= '0;
    else if (tick_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/sleep_clk_ctrl.sv
module sleep_clk_ctrl
  import sleep_ctrl_pkg::*;
#(
  parameter int unsigned N_IRQ = 4,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_en_i,
  input  logic             sleep_req_i,
  input  logic [2:0]       mode_i,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic [N_IRQ-1:0] irq_async_i,
  input  logic             rst_req_i,
  input  logic             ref_tick_i,
  input  logic [CNT_W-1:0] startup_ticks_i,
  output logic             clk_en_cpu_o,
  output logic             clk_en_io_o,
  output logic             clk_en_async_o,
  output logic             clk_en_adc_o,
  output logic             clk_en_osc_o,
  output logic             wake_pulse_o,
  output logic [2:0]       wake_mode_o
);

  ctrl_state_e state_q, state_d;
  logic [2:0]  mode_q, mode_d;
  logic        pulse_q, pulse_d;

  logic    req_valid, req_async_only, req_slow;
  dom_en_t req_keep;
  logic    cur_valid, cur_async_only, cur_slow;
  dom_en_t cur_keep;
  logic    wake;
  logic    wait_done;
  dom_en_t en_state, en_out;

  sleep_mode_decode u_req_dec (
    .mode_i      (mode_i),
    .valid_o     (req_valid),
    .async_only_o(req_async_only),
    .slow_wake_o (req_slow),
    .keep_o      (req_keep)
  );

  sleep_mode_decode u_cur_dec (
    .mode_i      (mode_q),
    .valid_o     (cur_valid),
    .async_only_o(cur_async_only),
    .slow_wake_o (cur_slow),
    .keep_o      (cur_keep)
  );

  sleep_wake_filter #(.N_IRQ(N_IRQ)) u_filter (
    .irq_i       (irq_i),
    .irq_en_i    (irq_en_i),
    .irq_async_i (irq_async_i),
    .async_only_i(cur_async_only),
    .wake_o      (wake)
  );

  sleep_osc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(state_q != ST_WAIT),
    .tick_i (ref_tick_i),
    .limit_i(startup_ticks_i),
    .done_o (wait_done)
  );

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    pulse_d = 1'b0;
    if (rst_req_i) begin
      state_d = ST_RUN;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (sleep_req_i && sleep_en_i && req_valid) begin
            state_d = ST_SLEEP;
            mode_d  = mode_i;
          end
        end
        ST_SLEEP: begin
          if (wake) begin
            if (cur_slow) begin
              state_d = ST_WAIT;
            end else begin
              state_d = ST_RUN;
              pulse_d = 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (wait_done) begin
            state_d = ST_RUN;
            pulse_d = 1'b1;
          end
        end
        default: state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      mode_q  <= 3'b000;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      pulse_q <= pulse_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_SLEEP: en_state = cur_keep;
      ST_WAIT:  en_state = DOM_OSC_ONLY;
      default:  en_state = DOM_ALL_ON;
    endcase
    // reset request must open clocks without waiting for an edge
    en_out = en_state | {5{rst_req_i}};
  end

  assign clk_en_cpu_o   = en_out.cpu;
  assign clk_en_io_o    = en_out.io;
  assign clk_en_async_o = en_out.async_tmr;
  assign clk_en_adc_o   = en_out.adc;
  assign clk_en_osc_o   = en_out.osc;
  assign wake_pulse_o   = pulse_q;
  assign wake_mode_o    = mode_q;

  logic unused_ok;
  assign unused_ok = ^{req_async_only, req_slow, req_keep, cur_valid};

endmodule

// File: rtl/sleep_clk_ctrl_chk.sv
module sleep_clk_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sleep_en_i,
  input logic rst_req_i,
  input logic clk_en_cpu_o,
  input logic clk_en_io_o,
  input logic clk_en_osc_o,
  input logic wake_pulse_o
);

  p_rst_req_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> clk_en_cpu_o);

  p_pulse_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_pulse_o |=> !wake_pulse_o);

  p_pulse_cpu_on_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_pulse_o |-> clk_en_cpu_o);

  p_no_sleep_unarmed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_cpu_o && !sleep_en_i) |=> clk_en_cpu_o);

  p_io_implies_cpu_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_io_o |-> !clk_en_cpu_o);

  p_osc_off_all_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_osc_o |-> (!clk_en_cpu_o && !clk_en_io_o));

  p_osc_restart_delay_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_osc_o && !rst_req_i) |=> (!clk_en_cpu_o || rst_req_i));

endmodule

bind sleep_clk_ctrl sleep_clk_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sleep_en_i  (sleep_en_i),
  .rst_req_i   (rst_req_i),
  .clk_en_cpu_o(clk_en_cpu_o),
  .clk_en_io_o (clk_en_io_o),
  .clk_en_osc_o(clk_en_osc_o),
  .wake_pulse_o(wake_pulse_o)
);

// File: tb/sleep_clk_ctrl_tb_top.sv
module sleep_clk_ctrl_tb_top;

  localparam int N_IRQ = 4;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sleep_en_i = 1'b0, sleep_req_i = 1'b0;
  logic [2:0] mode_i = 3'b000;
  logic [N_IRQ-1:0] irq_i = '0, irq_en_i = '0, irq_async_i = 4'b0001;
  logic rst_req_i = 1'b0, ref_tick_i = 1'b0;
  logic [CNT_W-1:0] startup_ticks_i = 8'd16;
  logic en_cpu, en_io, en_async, en_adc, en_osc, pulse;
  logic [2:0] wmode;

  always #5 clk = ~clk;

  sleep_clk_ctrl #(.N_IRQ(N_IRQ), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_en_i(sleep_en_i), .sleep_req_i(sleep_req_i),
    .mode_i(mode_i), .irq_i(irq_i), .irq_en_i(irq_en_i), .irq_async_i(irq_async_i),
    .rst_req_i(rst_req_i), .ref_tick_i(ref_tick_i), .startup_ticks_i(startup_ticks_i),
    .clk_en_cpu_o(en_cpu), .clk_en_io_o(en_io), .clk_en_async_o(en_async),
    .clk_en_adc_o(en_adc), .clk_en_osc_o(en_osc), .wake_pulse_o(pulse), .wake_mode_o(wmode)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";

  // reference model: 0 run, 1 asleep, 2 oscillator wait
  int m_st = 0, m_cnt = 0;
  logic [2:0] m_mode = 3'b000;
  logic m_pulse = 1'b0;

  function automatic bit code_ok(logic [2:0] c);
    return c inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b110};
  endfunction

  function automatic logic [4:0] exp_en(int st, logic [2:0] md, logic rr);
    logic [4:0] e;
    if (st == 0) e = 5'b11111;
    else if (st == 2) e = 5'b00001;
    else case (md)
      3'b000: e = 5'b01111;
      3'b001: e = 5'b00111;
      3'b010: e = 5'b00000;
      3'b011: e = 5'b00100;
      default: e = 5'b00001;
    endcase
    return rr ? 5'b11111 : e;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_cnt = 0; m_mode = 3'b000; m_pulse = 1'b0;
    end else begin
      m_pulse = 1'b0;
      if (rst_req_i) m_st = 0;
      else if (m_st == 0) begin
        if (sleep_req_i && sleep_en_i && code_ok(mode_i)) begin
          m_st = 1; m_mode = mode_i;
        end
      end else if (m_st == 1) begin
        logic deep;
        deep = (m_mode == 3'b010) || (m_mode == 3'b011) || (m_mode == 3'b110);
        if ((irq_i & irq_en_i & (deep ? irq_async_i : 4'b1111)) != 0) begin
          if (m_mode == 3'b010 || m_mode == 3'b011) begin m_st = 2; m_cnt = 0; end
          else begin m_st = 0; m_pulse = 1'b1; end
        end
      end else begin
        if (m_cnt >= int'(startup_ticks_i)) begin m_st = 0; m_pulse = 1'b1; end
        else if (ref_tick_i) m_cnt++;
      end
    end
  end

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison after inputs settle
  always @(negedge clk) begin
    #1;
    if (rst_ni)
      chk(cur_req, {en_cpu, en_io, en_async, en_adc, en_osc, pulse, wmode},
          {exp_en(m_st, m_mode, rst_req_i), m_pulse, m_mode});
  end

  int tick_div = 0;
  always @(negedge clk) begin
    tick_div = (tick_div == 2) ? 0 : tick_div + 1;
    ref_tick_i <= (tick_div == 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic req_sleep(logic [2:0] m);
    @(negedge clk); mode_i = m; sleep_req_i = 1'b1;
    @(negedge clk); sleep_req_i = 1'b0;
  endtask

  task automatic fire(logic [3:0] lines);
    @(negedge clk); irq_i = lines;
    @(negedge clk); irq_i = '0;
  endtask

  task automatic wait_pulse();
    int k = 0;
    while (!pulse && k < 200) begin @(negedge clk); #2; k++; end
  endtask

  initial begin
    irq_en_i = 4'b0011;
    cycles(3);
    #2 chk("R1", {en_cpu, en_io, en_async, en_adc, en_osc, pulse, wmode}, 9'b11111_0_000);
    rst_ni = 1'b1;
    cycles(2);
    #2 chk("R1", {en_cpu, en_io, en_async, en_adc, en_osc, pulse, wmode}, 9'b11111_0_000);

    cur_req = "R2";
    req_sleep(3'b000); cycles(2);
    #2 chk("R2", {8'b0, en_cpu}, 9'd1);
    sleep_en_i = 1'b1;
    req_sleep(3'b100); cycles(2);
    #2 chk("R2", {8'b0, en_cpu}, 9'd1);
    req_sleep(3'b111); cycles(2);

    cur_req = "R3";
    req_sleep(3'b000);
    #2 chk("R3", {4'b0, en_cpu, en_io, en_async, en_adc, en_osc}, 9'b01111);
    cur_req = "R4";
    fire(4'b0010);
    #2 chk("R6", {7'b0, en_cpu, pulse}, 9'b11);
    cycles(1);
    #2 chk("R8", {6'b0, pulse, wmode[1:0]}, 9'b000);

    cur_req = "R3";
    req_sleep(3'b001);
    #2 chk("R3", {4'b0, en_cpu, en_io, en_async, en_adc, en_osc}, 9'b00111);
    cur_req = "R4";
    fire(4'b0100); cycles(2);
    #2 chk("R4", {8'b0, en_cpu}, 9'd0);
    cur_req = "R6";
    fire(4'b0010); cycles(2);

    cur_req = "R5";
    req_sleep(3'b010);
    #2 chk("R3", {4'b0, en_cpu, en_io, en_async, en_adc, en_osc}, 9'b00000);
    cur_req = "R9";
    req_sleep(3'b000); cycles(1);
    #2 chk("R9", {6'b0, wmode}, 9'b010);
    cur_req = "R4";
    fire(4'b0010); cycles(3);
    #2 chk("R4", {8'b0, en_osc}, 9'd0);
    cur_req = "R5";
    fire(4'b0001);
    #2 chk("R5", {4'b0, en_cpu, en_io, en_async, en_adc, en_osc}, 9'b00001);
    wait_pulse();
    chk("R8", {5'b0, pulse, wmode}, 9'b1_010);
    cycles(2);

    cur_req = "R5";
    startup_ticks_i = 8'd0;
    req_sleep(3'b011);
    #2 chk("R3", {4'b0, en_cpu, en_io, en_async, en_adc, en_osc}, 9'b00100);
    fire(4'b0001); cycles(3);
    startup_ticks_i = 8'd3;
    req_sleep(3'b011); fire(4'b0011); cycles(16);

    cur_req = "R6";
    req_sleep(3'b110);
    #2 chk("R3", {4'b0, en_cpu, en_io, en_async, en_adc, en_osc}, 9'b00001);
    fire(4'b0001);
    #2 chk("R6", {4'b0, en_cpu, en_io, en_async, en_adc, en_osc}, 9'b11111);
    cycles(2);

    cur_req = "R7";
    startup_ticks_i = 8'd16;
    req_sleep(3'b010);
    @(negedge clk); irq_i = 4'b0001; rst_req_i = 1'b1;
    #2 chk("R7", {4'b0, en_cpu, en_io, en_async, en_adc, en_osc}, 9'b11111);
    @(negedge clk); irq_i = '0; rst_req_i = 1'b0;
    #2 chk("R7", {7'b0, en_cpu, pulse}, 9'b10);
    cycles(2);
    req_sleep(3'b011); fire(4'b0001); cycles(4);
    @(negedge clk); rst_req_i = 1'b1;
    @(negedge clk); rst_req_i = 1'b0;
    #2 chk("R7", {7'b0, en_cpu, pulse}, 9'b10);
    cycles(60);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule